// File: doc/BRIEF.md
# Stereo Second-Order PDM Noise Shaper

This block turns two streams of oversampled 16-bit signed audio samples into two 1-bit pulse-density streams, one for the left channel and one for the right, for use ahead of an analog reconstruction filter. Each channel is a loop of two cascaded integrators feeding a 1-bit quantizer. The quantizer decision is fed back into both integrators as plus or minus full scale. The quantization error therefore reaches the output through a (1 − z⁻¹)² high-pass shape, and the signal passes through with a two-step delay.

A new sample pair is captured whenever `smp_valid` is high. The captured pair is reused on every modulator step until the next capture. A modulator step happens on each clock edge where `mod_en` is high; in a typical system this enable pulses at 192 times the audio rate. Both channels step on the same edge and update their bits together. Each integrator is clamped to a parameterised magnitude, so the loop recovers from overload instead of wrapping.

Top module: `pdm_shaper_stereo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both integrators of both channels and the captured samples. After reset both output bits read 1.
- R2: With a zero sample after reset, each channel emits the repeating bit sequence 0,0,1,1 on the first, second, third and fourth enabled steps, and so on. This is a 50% ones-density.
- R3: For a held DC sample x (16-bit two's complement, full scale FS = 32768), the count of ones over 4096 enabled steps lies within 6 of 4096·(x/FS + 1)/2. This holds at the range ends too, including x = −32768. Each step changes the first integrator by at most 2·FS.
- R4: A sample is captured only on an edge with `smp_valid` high. Changes on `smp_left`/`smp_right` while `smp_valid` is low have no effect on the output.
- R5: On an edge with `mod_en` low, neither the integrators nor the output bits change. Stepping resumes from the same state when `mod_en` returns high.
- R6: The two channels are independent loops clocked on the same edge. Equal samples from equal state give identical bit streams, and different samples give each channel its own density.
- R7: Both integrators stay within ±LIMIT at all times. After a long near-full-scale input, a zero input brings the density back to 50% (512 ± 8 ones in 1024 steps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Modulator step enable |
| smp_valid | input | 1 | Capture strobe for the sample pair |
| smp_left | input | DW | Left sample, two's complement |
| smp_right | input | DW | Right sample, two's complement |
| bit_left | output | 1 | Left pulse-density bit |
| bit_right | output | 1 | Right pulse-density bit |

## Verification
The bound checker watches, on every cycle, the clamp bound on all four integrators and the clearing effect of reset. It also checks that state and bits stay frozen when the enable is low, that a strobe captures the sample, that the first integrator's step size is bounded, and that equal channel states advance in lockstep. The exact 0,0,1,1 start-up sequence and the long-window ones-density for many DC levels, including the negative full-scale end, can only be shown by the bench's scenarios. The same holds for the resistance to changes on the sample lines without a strobe and for recovery after overload.

// File: rtl/pdm_shaper_pkg.sv
package pdm_shaper_pkg;
   localparam int NUM_CH = 2;
   typedef enum int {CH_LEFT = 0, CH_RIGHT = 1} chan_e;

   function automatic int full_scale(input int dw);
      return 1 << (dw - 1);
   endfunction
endpackage

// File: rtl/pdm_sample_hold.sv
module pdm_sample_hold #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] dout
);
   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/pdm_clamp_integ.sv
module pdm_clamp_integ #(
   parameter int IW    = 20,
   parameter int DLW   = 18,
   parameter int LIMIT = 262144
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic signed [DLW-1:0] delta,
   output logic signed [IW-1:0]  q
);
   localparam int SW = IW + 2;
   localparam logic signed [SW-1:0] POS_LIM = SW'(LIMIT);
   localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

   if (DLW > IW + 1) begin : g_bad_dlw
      $error("delta wider than integrator allows");
   end

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] clamped;

   always_comb begin
      sum = {{2{q[IW-1]}}, q} + {{(SW-DLW){delta[DLW-1]}}, delta};
      if (sum > POS_LIM)      clamped = POS_LIM;
      else if (sum < NEG_LIM) clamped = NEG_LIM;
      else                    clamped = sum;
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= clamped[IW-1:0];
   end
endmodule

// File: rtl/pdm_loop_channel.sv
module pdm_loop_channel #(
   parameter int DW    = 16,
   parameter int IW    = 20,
   parameter int LIMIT = 262144
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [DW-1:0] x,
   output logic                 bit_o,
   output logic signed [IW-1:0] int1_o,
   output logic signed [IW-1:0] int2_o
);
   localparam int FW   = DW + 2;
   localparam int PADW = IW - FW;
   localparam logic signed [FW-1:0] FS_P = FW'(pdm_shaper_pkg::full_scale(DW));

   logic signed [FW-1:0] fb;
   logic signed [FW-1:0] d1;
   logic signed [IW:0]   d2;
   logic signed [IW:0]   fb2x;
   logic signed [IW:0]   i1x;

   // quantizer: non-negative second integrator gives a one
   assign bit_o = ~int2_o[IW-1];

   always_comb begin
      fb   = bit_o ? FS_P : -FS_P;
      d1   = {{2{x[DW-1]}}, x} - fb;
      fb2x = {{PADW{fb[FW-1]}}, fb, 1'b0};
      i1x  = {int1_o[IW-1], int1_o};
      d2   = i1x - fb2x;
   end

   pdm_clamp_integ #(.IW(IW), .DLW(FW), .LIMIT(LIMIT)) u_int1 (
      .clk(clk), .rst(rst), .en(en), .delta(d1), .q(int1_o)
   );

   pdm_clamp_integ #(.IW(IW), .DLW(IW + 1), .LIMIT(LIMIT)) u_int2 (
      .clk(clk), .rst(rst), .en(en), .delta(d2), .q(int2_o)
   );
endmodule

// File: rtl/pdm_shaper_stereo.sv
module pdm_shaper_stereo #(
   parameter int DW    = 16,
   parameter int IW    = 20,
   parameter int LIMIT = 262144
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 mod_en,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] smp_left,
   input  logic signed [DW-1:0] smp_right,
   output logic                 bit_left,
   output logic                 bit_right
);
   import pdm_shaper_pkg::*;

   if (IW < DW + 4) begin : g_bad_iw
      $error("IW must be at least DW+4");
   end
   if (LIMIT < 4 * (1 << (DW - 1)) || LIMIT >= (1 << (IW - 1))) begin : g_bad_lim
      $error("LIMIT out of range for DW/IW");
   end

   logic signed [DW-1:0] smp_in  [NUM_CH];
   logic signed [DW-1:0] smp_hld [NUM_CH];
   logic signed [IW-1:0] int1    [NUM_CH];
   logic signed [IW-1:0] int2    [NUM_CH];
   logic                 bits    [NUM_CH];

   assign smp_in[CH_LEFT]  = smp_left;
   assign smp_in[CH_RIGHT] = smp_right;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pdm_sample_hold #(.DW(DW)) u_hold (
         .clk(clk), .rst(rst), .load(smp_valid),
         .din(smp_in[c]), .dout(smp_hld[c])
      );
      pdm_loop_channel #(.DW(DW), .IW(IW), .LIMIT(LIMIT)) u_loop (
         .clk(clk), .rst(rst), .en(mod_en), .x(smp_hld[c]),
         .bit_o(bits[c]), .int1_o(int1[c]), .int2_o(int2[c])
      );
   end

   assign bit_left  = bits[CH_LEFT];
   assign bit_right = bits[CH_RIGHT];
endmodule

// File: rtl/pdm_shaper_chk.sv
module pdm_shaper_chk #(
   parameter int DW    = 16,
   parameter int IW    = 20,
   parameter int LIMIT = 262144
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 mod_en,
   input logic                 smp_valid,
   input logic signed [DW-1:0] smp_left,
   input logic signed [DW-1:0] smp_right,
   input logic signed [DW-1:0] hold_l,
   input logic signed [DW-1:0] hold_r,
   input logic signed [IW-1:0] i1_l,
   input logic signed [IW-1:0] i2_l,
   input logic signed [IW-1:0] i1_r,
   input logic signed [IW-1:0] i2_r,
   input logic                 bit_left,
   input logic                 bit_right
);
   localparam logic signed [IW-1:0] LIM_P = IW'(LIMIT);
   localparam logic signed [IW:0]   STEP_P = (IW+1)'(2 * (1 << (DW - 1)));

   logic signed [IW-1:0] prev_i1_l;
   logic signed [IW:0]   step_l;

   always_ff @(posedge clk) prev_i1_l <= i1_l;
   assign step_l = {i1_l[IW-1], i1_l} - {prev_i1_l[IW-1], prev_i1_l};

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (i1_l == 0 && i2_l == 0 && i1_r == 0 && i2_r == 0 &&
                      hold_l == 0 && hold_r == 0 && bit_left && bit_right)); // R1

   AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      (i1_l <= LIM_P && i1_l >= -LIM_P && i2_l <= LIM_P && i2_l >= -LIM_P &&
       i1_r <= LIM_P && i1_r >= -LIM_P && i2_r <= LIM_P && i2_r >= -LIM_P)); // R7

   AST_FROZEN_NO_EN: assert property (@(posedge clk) disable iff (rst)
      (!$past(mod_en) && !$past(rst)) |->
         ($stable(i1_l) && $stable(i2_l) && $stable(i1_r) && $stable(i2_r) &&
          $stable(bit_left) && $stable(bit_right))); // R5

   AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      smp_valid |=> (hold_l == $past(smp_left) && hold_r == $past(smp_right))); // R4

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
      ($past(mod_en) && !$past(rst)) |-> (step_l <= STEP_P && step_l >= -STEP_P)); // R3

   AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
      (hold_l == hold_r && i1_l == i1_r && i2_l == i2_r && !smp_valid) |=>
         (i1_l == i1_r && i2_l == i2_r && bit_left == bit_right)); // R6
endmodule

bind pdm_shaper_stereo pdm_shaper_chk #(.DW(DW), .IW(IW), .LIMIT(LIMIT)) u_chk (
   .clk(clk), .rst(rst), .mod_en(mod_en), .smp_valid(smp_valid),
   .smp_left(smp_left), .smp_right(smp_right),
   .hold_l(smp_hld[0]), .hold_r(smp_hld[1]),
   .i1_l(int1[0]), .i2_l(int2[0]), .i1_r(int1[1]), .i2_r(int2[1]),
   .bit_left(bit_left), .bit_right(bit_right)
);

// File: tb/pdm_shaper_stereo_tb.sv
module pdm_shaper_stereo_tb;
   localparam int FS  = 32768;
   localparam int WIN = 4096;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               mod_en = 1'b1;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_left = '0;
   logic signed [15:0] smp_right = '0;
   logic               bit_left, bit_right;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pdm_shaper_stereo u_dut (
      .clk(clk), .rst(rst), .mod_en(mod_en), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right),
      .bit_left(bit_left), .bit_right(bit_right)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; mod_en = 1'b1; smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic load(input int l, input int r);
      @(negedge clk);
      smp_valid = 1'b1; smp_left = 16'(l); smp_right = 16'(r);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic measure(input int n, output int ol, output int orr);
      ol = 0; orr = 0;
      repeat (n) begin
         @(negedge clk);
         ol += int'(bit_left);
         orr += int'(bit_right);
      end
   endtask

   function automatic int absi(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // R3 / R6: density of held DC levels, separate value per channel
   task automatic dc_check(input int vl, input int vr);
      int ol, orr;
      load(vl, vr);
      repeat (256) @(negedge clk);
      measure(WIN, ol, orr);
      // expected ones = WIN*(v+FS)/(2FS) = (v+FS)/16, tolerance 6 ones
      check(absi(16 * ol - (vl + FS)) <= 96, "R3", $sformatf("left density x=%0d", vl),
            ol, (vl + FS) / 16);
      check(absi(16 * orr - (vr + FS)) <= 96, "R6", $sformatf("right density x=%0d", vr),
            orr, (vr + FS) / 16);
   endtask

   initial begin
      int ol, orr, mism;
      // R1: dirty state then reset must give the zero pattern
      do_reset();
      load(20000, -20000);
      repeat (100) @(negedge clk);
      do_reset();
      check(bit_left == 1'b1, "R1", "left bit after reset", int'(bit_left), 1);
      check(bit_right == 1'b1, "R1", "right bit after reset", int'(bit_right), 1);

      // R2: zero input pattern 0,0,1,1 repeating
      for (int k = 1; k <= 12; k++) begin
         int e;
         @(negedge clk);
         e = ((k % 4) == 3 || (k % 4) == 0) ? 1 : 0;
         check(int'(bit_left) == e && int'(bit_right) == e, "R2",
               $sformatf("zero pattern step %0d", k), int'(bit_left), e);
      end

      // R5: freeze mid-pattern and resume
      do_reset();
      @(negedge clk);
      @(negedge clk);
      check(bit_left == 1'b0, "R5", "second step before freeze", int'(bit_left), 0);
      mod_en = 1'b0;
      mism = 0;
      repeat (20) begin
         @(negedge clk);
         if (bit_left != 1'b0 || bit_right != 1'b0) mism++;
      end
      check(mism == 0, "R5", "bits changed while disabled", mism, 0);
      mod_en = 1'b1;
      @(negedge clk);
      check(bit_left == 1'b1, "R5", "third step after resume", int'(bit_left), 1);
      @(negedge clk);
      check(bit_left == 1'b1, "R5", "fourth step after resume", int'(bit_left), 1);
      @(negedge clk);
      check(bit_left == 1'b0, "R5", "fifth step after resume", int'(bit_left), 0);

      // R3 / R6: DC sweep, mirrored per channel
      dc_check(-24576, 24576);
      dc_check(-8192, 8192);
      dc_check(0, 0);
      dc_check(5000, -5000);
      dc_check(16384, -16384);
      dc_check(30000, -30000);
      dc_check(-32768, 32767);

      // R4: sample lines move without strobe
      load(16384, -16384);
      @(negedge clk);
      smp_left = -16'sd30000; smp_right = 16'sd30000;
      repeat (256) @(negedge clk);
      measure(WIN, ol, orr);
      check(absi(16 * ol - (16384 + FS)) <= 96, "R4", "left ignores unstrobed data",
            ol, (16384 + FS) / 16);
      check(absi(16 * orr - (-16384 + FS)) <= 96, "R4", "right ignores unstrobed data",
            orr, (-16384 + FS) / 16);

      // R6: equal inputs from equal state give equal streams
      do_reset();
      load(12345, 12345);
      mism = 0;
      repeat (512) begin
         @(negedge clk);
         if (bit_left != bit_right) mism++;
      end
      check(mism == 0, "R6", "equal channels diverged", mism, 0);

      // R7: overload then recovery to 50%
      do_reset();
      load(32767, -32768);
      repeat (8192) @(negedge clk);
      load(0, 0);
      repeat (128) @(negedge clk);
      measure(1024, ol, orr);
      check(absi(ol - 512) <= 8, "R7", "left recovery density", ol, 512);
      check(absi(orr - 512) <= 8, "R7", "right recovery density", orr, 512);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule